// File: doc/BRIEF.md
# Four-Phase Two-Output Clock Sequencer

This block divides a free-running system clock into a repeating sequence of four phases, numbered 0 to 3. It drives two single-bit phase strobes. The first strobe is high only in phase 1 and the second only in phase 3. Both strobes are low in phases 0 and 2, so the two high phases are always separated by a phase where neither is high. Downstream logic uses these strobes as non-overlapping enables. The current phase index is also brought out so that other logic can align to the sequence.

The block is also the source of the reset used by registers in the rest of the design. An external synchronous active-high reset returns the sequencer to phase 0. A reset-out line follows that reset and then stays high for a programmable number of clock periods after it is released. By default that number is one full four-phase round. Every output comes straight from a flip-flop, so no output can glitch.

Top module: `quad_phase_clkgen`

## Requirements
- R1: On any rising edge that samples `rst_i` high, the block sets `phase_o` to 0 and both `ph_a_o` and `ph_b_o` to 0, and sets `rst_out_o` to 1.
- R2: On each rising edge that samples `rst_i` low, `phase_o` advances by one. It wraps from 3 to 0.
- R3: `ph_a_o` is 1 exactly in the cycles where `phase_o` equals 1 (parameter `A_PHASE`).
- R4: `ph_b_o` is 1 exactly in the cycles where `phase_o` equals 3 (parameter `B_PHASE`).
- R5: `ph_a_o` and `ph_b_o` are never 1 together. Both are 0 whenever `phase_o` is 0 or 2.
- R6: After the last rising edge that samples `rst_i` high, `rst_out_o` stays 1 for exactly `HOLD` clock periods (default 4: phases 0, 1, 2 and 3 of the first round). It then falls to 0 as the phase returns to 0 and stays 0 until the next reset.
- R7: A reset asserted at any phase, including a one-cycle pulse, restarts the sequence at phase 0 and restarts the full `HOLD`-period reset-out stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_i | input | 1 | External synchronous active-high reset |
| phase_o | output | 2 | Current phase index, 0 to 3 |
| ph_a_o | output | 1 | First phase strobe, high in phase 1 |
| ph_b_o | output | 1 | Second phase strobe, high in phase 3 |
| rst_out_o | output | 1 | Stretched reset for the registers of the design |

## Verification
The bench applies reset in each of the four phases and as a single-cycle pulse. A design that failed to restart cleanly would continue from the interrupted phase, or would keep a shortened reset-out stretch. It counts reset-out periods exactly at the release boundary. An off-by-one stretch would drop reset-out in phase 3 or keep it high into the next phase 0. Long random runs with sparse resets check every cycle against a reference model of the phase and strobe pattern. A strobe decoded one phase early or late, or the two strobes overlapping, would show up there.

// File: rtl/qp_pkg.sv
package qp_pkg;
  localparam int unsigned PHASE_W    = 2;
  localparam int unsigned NUM_PHASES = 1 << PHASE_W;
  localparam int unsigned NUM_STROBE = 2;

  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/qp_phase_ctr.sv
module qp_phase_ctr
  import qp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  output phase_t phase_q_o,
  output phase_t phase_d_o
);
  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    if (rst_i) phase_d = '0;
    else       phase_d = phase_t'(phase_q + phase_t'(1));
  end

  always_ff @(posedge clk_i) begin
    phase_q <= phase_d;
  end

  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;

  // R2: one step per clock, wrapping modulo four
  p_step_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (phase_q == phase_t'($past(phase_q) + phase_t'(1))));
endmodule

// File: rtl/qp_strobe_dec.sv
module qp_strobe_dec
  import qp_pkg::*;
#(
  parameter phase_t A_PHASE = phase_t'(1),
  parameter phase_t B_PHASE = phase_t'(3)
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  phase_t                phase_d_i,
  output logic [NUM_STROBE-1:0] strobe_o
);
  function automatic phase_t active_phase(input int unsigned idx);
    return (idx == 0) ? A_PHASE : B_PHASE;
  endfunction

  logic [NUM_STROBE-1:0] strobe_q;

  for (genvar g = 0; g < NUM_STROBE; g++) begin : g_strobe
    always_ff @(posedge clk_i) begin
      if (rst_i) strobe_q[g] <= 1'b0;
      else       strobe_q[g] <= (phase_d_i == active_phase(g));
    end
  end

  assign strobe_o = strobe_q;

  // R5: the strobes never overlap
  p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(strobe_q));
endmodule

// File: rtl/qp_reset_stretch.sv
module qp_reset_stretch #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic rst_out_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          rst_out_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q     <= CW'(HOLD);
      rst_out_q <= 1'b1;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      rst_out_q <= (cnt_q > CW'(1));
    end
  end

  assign rst_out_o = rst_out_q;

  // R1: reset always loads a full stretch
  p_load_r1: assert property (@(posedge clk_i)
    rst_i |=> (rst_out_q && cnt_q == CW'(HOLD)));
  // R6: once the stretch has run out, reset-out stays low
  p_stay_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q == '0) |=> (cnt_q == '0 && !rst_out_q));
endmodule

// File: rtl/quad_phase_clkgen.sv
module quad_phase_clkgen
  import qp_pkg::*;
#(
  parameter int unsigned HOLD    = 4,
  parameter int unsigned A_PHASE = 1,
  parameter int unsigned B_PHASE = 3
) (
  input  logic       clk_i,
  input  logic       rst_i,
  output logic [1:0] phase_o,
  output logic       ph_a_o,
  output logic       ph_b_o,
  output logic       rst_out_o
);
  localparam phase_t A_P = phase_t'(A_PHASE);
  localparam phase_t B_P = phase_t'(B_PHASE);

  phase_t                phase_q;
  phase_t                phase_d;
  logic [NUM_STROBE-1:0] strobe;

  qp_phase_ctr u_ctr (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .phase_q_o (phase_q),
    .phase_d_o (phase_d)
  );

  qp_strobe_dec #(.A_PHASE(A_P), .B_PHASE(B_P)) u_dec (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .phase_d_i (phase_d),
    .strobe_o  (strobe)
  );

  qp_reset_stretch #(.HOLD(HOLD)) u_rst (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rst_out_o (rst_out_o)
  );

  assign phase_o = phase_q;
  assign ph_a_o  = strobe[0];
  assign ph_b_o  = strobe[1];

  // R3: first strobe aligned with its phase
  p_a_align_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ph_a_o == (phase_o == A_P));
  // R4: second strobe aligned with its phase
  p_b_align_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    ph_b_o == (phase_o == B_P));
  // R7: reset at any phase restarts at phase 0 with strobes low
  p_restart_r7: assert property (@(posedge clk_i)
    rst_i |=> (phase_o == 2'd0 && !ph_a_o && !ph_b_o && rst_out_o));
endmodule

// File: tb/test_quad_phase_clkgen.sv
`timescale 1ns/1ps
module test_quad_phase_clkgen;
  localparam int unsigned HOLD = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] phase;
  logic       ph_a, ph_b, rst_out;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [1:0] m_ph  = 2'd0;
  int         m_cnt = HOLD;
  bit         m_valid = 1'b0;

  always #2 clk = ~clk;

  quad_phase_clkgen #(.HOLD(HOLD)) i_quad_phase_clkgen (
    .clk_i(clk), .rst_i(rst), .phase_o(phase),
    .ph_a_o(ph_a), .ph_b_o(ph_b), .rst_out_o(rst_out)
  );

  function automatic bit exp_a(input logic [1:0] p); return p == 2'd1; endfunction
  function automatic bit exp_b(input logic [1:0] p); return p == 2'd3; endfunction

  // reference model, updated on the edges that the design also uses
  always @(posedge clk) begin
    cycles++;
    m_valid <= 1'b1;
    if (rst) begin
      m_ph  <= 2'd0;
      m_cnt <= HOLD;
    end else begin
      m_ph  <= m_ph + 2'd1;
      if (m_cnt != 0) m_cnt <= m_cnt - 1;
    end
  end

  task automatic chk(input int got, input int exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cycles);
    end
  endtask

  // checks every cycle, away from the active edge
  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk(phase, m_ph, "R2 phase index");
      chk(ph_a, exp_a(m_ph), "R3 first strobe");
      chk(ph_b, exp_b(m_ph), "R4 second strobe");
      chk(ph_a && ph_b, 0, "R5 strobe overlap");
      chk(rst_out, (m_cnt != 0), "R6 reset-out stretch");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    cyc(3);
    // R1 reset state
    chk(phase, 0, "R1 phase in reset");
    chk(ph_a | ph_b, 0, "R1 strobes in reset");
    chk(rst_out, 1, "R1 reset-out in reset");
    rst = 1'b0;
    // R6 exact stretch boundary: high in periods 0..3, low next phase 0
    cyc(3);
    chk(rst_out, 1, "R6 high in phase 3 after release");
    chk(phase, 3, "R6 phase 3 reached");
    cyc(1);
    chk(rst_out, 0, "R6 low at next phase 0");
    chk(phase, 0, "R2 wrap to 0");
    cyc(10);
    // R7 reset at each phase
    for (int p = 0; p < 4; p++) begin
      while (phase != p[1:0]) cyc(1);
      rst = 1'b1;
      cyc(1);
      rst = 1'b0;
      chk(phase, 0, "R7 restart phase");
      chk(rst_out, 1, "R7 stretch restarted");
      cyc(4);
      chk(rst_out, 0, "R7 stretch length after pulse");
      cyc(p + 3);
    end
    // random sparse resets, fixed seed
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 3000; i++) begin
      rst = (($urandom() % 16) == 0);
      cyc(1);
    end
    rst = 1'b0;
    cyc(8);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule